// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block turns an 8-bit timer count into a single output waveform and decides whether that waveform or a plain port value reaches the pin. A small counter is built in so the unit stands alone. It runs in one of four count styles: free-running wrap, clear at a programmable ceiling, single-slope PWM, and dual-slope (up/down) PWM. The counter advances only on cycles where the count-enable input is high.

A 2-bit output-action code selects what a compare hit does. Its meaning depends on the count style. In the non-PWM styles a hit toggles, clears or sets the waveform bit. In single-slope PWM a hit and the ceiling act as a pair of opposite edges. In dual-slope PWM the action on a hit depends on the count direction. In both PWM styles one code is reserved and behaves as if the output were disconnected.

The compare value is loaded at once in the non-PWM styles. In the PWM styles it is held in a shadow register and goes live at the ceiling, so a period is never cut short. A synchronous force input applies the non-PWM hit action on demand.

Top module: `cmp_wave_unit`

## Requirements
- R1: After reset, cnt_o is 0, cnt_down_o is 0, wave_o is 0 and the live compare value is 0.
- R2: The count advances by one only on cycles with cnt_en_i high. wave_mode_i encodings are 00 free-run, 01 clear-at-ceiling, 10 single-slope PWM and 11 dual-slope PWM. In free-run the count wraps from 255 to 0. In 01 and 10 a count at or above top_i goes to 0 on the next enabled cycle.
- R3: In dual-slope mode (11) the count rises to top_i, then falls to 0, then rises again, and cnt_down_o is high while it falls. With top_i equal to 0 the count stays at 0. Outside mode 11 cnt_down_o is 0.
- R4: A hit is an enabled cycle whose count equals the live compare value. In modes 00 and 01, out_mode_i 01 toggles wave_o on a hit, 10 clears it and 11 sets it, all on the edge that ends the hit cycle. With 00 wave_o is unchanged.
- R5: In mode 10 with out_mode_i 10, wave_o goes to 0 on a hit and to 1 on an enabled cycle at the ceiling. Code 11 gives the inverse. The ceiling action wins when both apply.
- R6: In mode 11 with out_mode_i 10, a hit while rising clears wave_o and a hit while falling sets it. Code 11 gives the inverse.
- R7: In modes 10 and 11, out_mode_i 00 or 01 leaves wave_o unchanged and ovr_o low. In modes 00 and 01 ovr_o is high for every nonzero code.
- R8: In mode 10 with the live compare value equal to top_i, wave_o is held at 1 for code 10 and at 0 for code 11 after the first enabled ceiling cycle.
- R9: In mode 11 with the live compare value equal to top_i, the hit at the ceiling is ignored and wave_o holds.
- R10: In modes 00 and 01 a cmp_we_i write takes effect on the next cycle. In modes 10 and 11 the written value goes live only on an enabled cycle whose count is at or above top_i.
- R11: In modes 00 and 01, force_i applies the R4 action of the current code without a hit or a count enable. In modes 10 and 11 force_i is ignored.
- R12: pin_o equals wave_o when ovr_o is high and port_val_i otherwise. pin_oe_o equals port_dir_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable tick |
| wave_mode_i | input | 2 | Count style: 00 free-run, 01 clear-at-ceiling, 10 single-slope PWM, 11 dual-slope PWM |
| top_i | input | 8 | Ceiling value for modes 01, 10, 11 |
| cmp_val_i | input | 8 | Compare value to write |
| cmp_we_i | input | 1 | Compare write strobe |
| out_mode_i | input | 2 | Output action code |
| force_i | input | 1 | Force a non-PWM compare action |
| port_val_i | input | 1 | General-purpose port value |
| port_dir_i | input | 1 | Port direction bit, enables the driver |
| cnt_o | output | 8 | Counter value |
| cnt_down_o | output | 1 | Counter is falling (dual-slope) |
| wave_o | output | 1 | Registered waveform bit |
| ovr_o | output | 1 | Waveform overrides the port value |
| pin_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin driver enable |

## Verification
The hardest case to reach is a compare write that lands in the same enabled cycle as a ceiling load, with the waveform edge and the new compare value both resolving on that one edge. With a steady enable and fixed writes this coincidence almost never happens. The stimulus therefore runs dual-slope and single-slope sweeps with a randomly gated enable and random compare writes clustered around the ceiling, including 0 and the ceiling itself. Each run is swept across all action codes so that the reserved code and the direction-dependent actions meet these collisions.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
  typedef enum logic [1:0] {
    WM_FREE  = 2'b00,
    WM_CEIL  = 2'b01,
    WM_FAST  = 2'b10,
    WM_DUAL  = 2'b11
  } wave_mode_e;
endpackage

// File: rtl/cwu_counter.sv
module cwu_counter
  import cwu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  wave_mode_e   mode_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         at_top_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] cnt_q, cnt_d, top_eff;
  logic         down_q, down_d;

  assign top_eff  = (mode_i == WM_FREE) ? CNT_MAX : top_i;
  assign at_top_o = cnt_q >= top_eff;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = (mode_i == WM_DUAL) ? down_q : 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        WM_FREE: cnt_d = cnt_q + ONE;
        WM_CEIL, WM_FAST: cnt_d = at_top_o ? '0 : cnt_q + ONE;
        WM_DUAL: begin
          if (top_i == '0) begin
            cnt_d  = '0;
            down_d = 1'b0;
          end else if (!down_q) begin
            if (at_top_o) begin
              cnt_d  = cnt_q - ONE;
              down_d = 1'b1;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q == '0) begin
            cnt_d  = ONE;
            down_d = 1'b0;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;

  // R2
  fast_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == WM_FAST && cnt_q >= top_i) |=> cnt_q == '0);

  // R3
  dual_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == WM_DUAL && !down_q && top_i != '0 && cnt_q >= top_i) |=> down_q);
endmodule

// File: rtl/cwu_cmp_reg.sv
module cwu_cmp_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pwm_i,
  input  logic         load_i,
  input  logic         we_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] ocr_o
);
  logic [W-1:0] shadow_q, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      if (we_i) shadow_q <= val_i;
      if (!pwm_i) begin
        if (we_i) live_q <= val_i;
      end else if (load_i) begin
        live_q <= shadow_q;  // old shadow: a same-cycle write waits one period
      end
    end
  end

  assign ocr_o = live_q;

  // R10
  ocr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && !load_i) |=> $stable(live_q));
endmodule

// File: rtl/cwu_wave_gen.sv
module cwu_wave_gen
  import cwu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wave_mode_e   mode_i,
  input  logic [1:0]   code_i,
  input  logic         tick_i,
  input  logic         force_i,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic         at_top_i,
  input  logic [W-1:0] ocr_i,
  input  logic [W-1:0] top_i,
  output logic         wave_o,
  output logic         ovr_o
);
  logic wave_q, wave_d, hit, pwm;

  assign pwm = (mode_i == WM_FAST) || (mode_i == WM_DUAL);
  assign hit = tick_i && (cnt_i == ocr_i);

  always_comb begin
    wave_d = wave_q;
    unique case (mode_i)
      WM_FREE, WM_CEIL: begin
        if (force_i || hit) begin
          unique case (code_i)
            2'b01: wave_d = ~wave_q;
            2'b10: wave_d = 1'b0;
            2'b11: wave_d = 1'b1;
            default: wave_d = wave_q;
          endcase
        end
      end
      WM_FAST: begin
        if (tick_i && code_i[1]) begin
          if (at_top_i)  wave_d = ~code_i[0];
          else if (hit)  wave_d = code_i[0];
        end
      end
      WM_DUAL: begin
        // compare == top: hit at the turn is dropped to avoid a glitch
        if (code_i[1] && hit && ocr_i != top_i)
          wave_d = down_i ? ~code_i[0] : code_i[0];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign wave_o = wave_q;
  assign ovr_o  = (code_i != 2'b00) && !(pwm && code_i == 2'b01);

  // R4
  nonpwm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwm && !force_i && !(tick_i && cnt_i == ocr_i)) |=> $stable(wave_q));

  // R8
  fast_flat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == WM_FAST && code_i == 2'b10 && ocr_i == top_i) |=> wave_q);

  // R9
  dual_top_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == WM_DUAL && ocr_i == top_i) |=> $stable(wave_q));

  // R7
  pwm_reserved_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && !code_i[1]) |=> $stable(wave_q));
endmodule

// File: rtl/cmp_wave_unit.sv
module cmp_wave_unit
  import cwu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_en_i,
  input  logic [1:0]   wave_mode_i,
  input  logic [W-1:0] top_i,
  input  logic [W-1:0] cmp_val_i,
  input  logic         cmp_we_i,
  input  logic [1:0]   out_mode_i,
  input  logic         force_i,
  input  logic         port_val_i,
  input  logic         port_dir_i,
  output logic [W-1:0] cnt_o,
  output logic         cnt_down_o,
  output logic         wave_o,
  output logic         ovr_o,
  output logic         pin_o,
  output logic         pin_oe_o
);
  wave_mode_e   mode;
  logic [W-1:0] cnt, ocr;
  logic         down, at_top, pwm;

  assign mode = wave_mode_e'(wave_mode_i);
  assign pwm  = (mode == WM_FAST) || (mode == WM_DUAL);

  cwu_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_en_i),
    .mode_i   (mode),
    .top_i    (top_i),
    .cnt_o    (cnt),
    .down_o   (down),
    .at_top_o (at_top)
  );

  cwu_cmp_reg #(.W(W)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm),
    .load_i (cnt_en_i && at_top),
    .we_i   (cmp_we_i),
    .val_i  (cmp_val_i),
    .ocr_o  (ocr)
  );

  cwu_wave_gen #(.W(W)) u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode),
    .code_i   (out_mode_i),
    .tick_i   (cnt_en_i),
    .force_i  (force_i),
    .cnt_i    (cnt),
    .down_i   (down),
    .at_top_i (at_top),
    .ocr_i    (ocr),
    .top_i    (top_i),
    .wave_o   (wave_o),
    .ovr_o    (ovr_o)
  );

  assign cnt_o      = cnt;
  assign cnt_down_o = down;
  assign pin_o      = ovr_o ? wave_o : port_val_i;
  assign pin_oe_o   = port_dir_i;
endmodule

// File: tb/cmp_wave_unit_bench.sv
module cmp_wave_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] top = 8'd0;
  logic [7:0] cmp_val = 8'd0;
  logic       cmp_we = 1'b0;
  logic [1:0] code = 2'b00;
  logic       frc = 1'b0;
  logic       port_val = 1'b0;
  logic       port_dir = 1'b0;
  logic [7:0] cnt_o;
  logic       down_o, wave_o, ovr_o, pin_o, pin_oe_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_wave_unit u_cmp_wave_unit (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .wave_mode_i(mode),
    .top_i(top), .cmp_val_i(cmp_val), .cmp_we_i(cmp_we), .out_mode_i(code),
    .force_i(frc), .port_val_i(port_val), .port_dir_i(port_dir),
    .cnt_o(cnt_o), .cnt_down_o(down_o), .wave_o(wave_o), .ovr_o(ovr_o),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  // reference model
  int m_cnt, m_buf, m_act;
  bit m_down, m_wave;

  always @(posedge clk or negedge rst_n) begin
    int  n_cnt, n_buf, n_act, tp, c0;
    bit  n_down, n_wave, ispwm, hit, attop;
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_wave = 0; m_buf = 0; m_act = 0;
    end else begin
      ispwm = (mode >= 2);
      tp    = (mode == 0) ? 255 : int'(top);
      attop = (m_cnt >= tp);
      hit   = cnt_en && (m_cnt == m_act);
      c0    = int'(code[0]);
      n_cnt = m_cnt; n_down = (mode == 3) ? m_down : 0;
      n_wave = m_wave; n_buf = m_buf; n_act = m_act;
      // waveform
      if (!ispwm) begin
        if (frc || hit) begin
          if (code == 2'b01) n_wave = !m_wave;
          else if (code == 2'b10) n_wave = 0;
          else if (code == 2'b11) n_wave = 1;
        end
      end else if (mode == 2) begin
        if (cnt_en && code[1]) begin
          if (attop) n_wave = (c0 == 0);
          else if (hit) n_wave = (c0 == 1);
        end
      end else begin
        if (code[1] && hit && m_act != int'(top))
          n_wave = m_down ? (c0 == 0) : (c0 == 1);
      end
      // counter
      if (cnt_en) begin
        if (mode == 0) n_cnt = (m_cnt + 1) % 256;
        else if (mode != 3) n_cnt = attop ? 0 : m_cnt + 1;
        else if (top == 0) begin n_cnt = 0; n_down = 0; end
        else if (!m_down) begin
          if (attop) begin n_cnt = m_cnt - 1; n_down = 1; end
          else n_cnt = m_cnt + 1;
        end else if (m_cnt == 0) begin n_cnt = 1; n_down = 0; end
        else n_cnt = m_cnt - 1;
      end
      // compare register
      if (cmp_we) n_buf = int'(cmp_val);
      if (!ispwm) begin
        if (cmp_we) n_act = int'(cmp_val);
      end else if (cnt_en && attop) n_act = m_buf;
      m_cnt = n_cnt; m_down = n_down; m_wave = n_wave; m_buf = n_buf; m_act = n_act;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s mode=%0d code=%0d cnt=%0d act=%0d exp=%0d",
               tag, mode, code, m_cnt, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    string ct, wt, pt;
    bit e_ovr;
    ct = (mode == 3) ? "R3" : "R2";
    wt = (mode < 2) ? "R4" : ((mode == 2) ? "R5" : "R6");
    e_ovr = (code != 0) && !(mode >= 2 && code == 2'b01);
    pt = (!code[1]) ? "R7" : "R12";
    chk({ct, " cnt ", tag}, int'(cnt_o), m_cnt);
    chk({"R3 dir ", tag}, int'(down_o), int'(m_down));
    chk({wt, " wave ", tag}, int'(wave_o), int'(m_wave));
    chk({pt, " ovr ", tag}, int'(ovr_o), int'(e_ovr));
    chk({"R12 pin ", tag}, int'(pin_o), int'(e_ovr ? m_wave : port_val));
    chk({"R12 oe ", tag}, int'(pin_oe_o), int'(port_dir));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cnt_en = 0; cmp_we = 0; frc = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_scen(input int md, input int cd, input int tp, input int ocr,
                          input int len, input int we_rate, input int frc_rate,
                          input bit full_en, input string tag);
    do_reset();
    mode = 2'(md); code = 2'(cd); top = 8'(tp);
    cmp_val = 8'(ocr); cmp_we = 1;
    @(negedge clk);
    check_all(tag);
    cmp_we = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check_all(tag);
      cnt_en   = full_en ? 1'b1 : (($urandom % 4) != 0);
      frc      = (frc_rate != 0) && (($urandom % frc_rate) == 0);
      port_val = 1'($urandom);
      port_dir = 1'($urandom);
      cmp_we   = (we_rate != 0) && (($urandom % we_rate) == 0);
      if (cmp_we) begin
        case ($urandom % 4)
          0: cmp_val = 8'd0;
          1: cmp_val = top;
          default: cmp_val = 8'($urandom % (tp + 3));
        endcase
      end
    end
  endtask

  initial begin
    int ocr_set[4];
    int md_tp;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 dir", int'(down_o), 0);
    chk("R1 wave", int'(wave_o), 0);
    // R1 live compare is 0: a hit at count 0 with set code raises wave
    code = 2'b11; mode = 2'b00; cnt_en = 1;
    @(negedge clk);
    chk("R1 cmp0 wave", int'(wave_o), 1);
    cnt_en = 0;

    for (int md = 0; md < 4; md++) begin
      md_tp = (md == 0) ? 255 : 37;
      ocr_set[0] = 0; ocr_set[1] = 17; ocr_set[2] = md_tp;
      ocr_set[3] = (md == 0) ? 128 : 50;
      for (int cd = 0; cd < 4; cd++) begin
        for (int k = 0; k < 4; k++) begin
          string tg;
          tg = "sweep";
          if (k == 2 && cd >= 2 && md == 2) tg = "R8";
          if (k == 2 && cd >= 2 && md == 3) tg = "R9";
          run_scen(md, cd, 37, ocr_set[k], (md == 0) ? 700 : 300, 0, 0, k[0], tg);
        end
      end
    end
    // R10 compare writes around the ceiling in every mode
    for (int md = 0; md < 4; md++)
      for (int cd = 1; cd < 4; cd++)
        run_scen(md, cd, 23, 5, 500, 6, 0, 1'b0, "R10");
    // R11 force in all modes (ignored in PWM)
    for (int md = 0; md < 4; md++)
      for (int cd = 0; cd < 4; cd++)
        run_scen(md, cd, 29, 11, 300, 0, 3, 1'b0, "R11");
    // R3 degenerate ceilings in dual-slope
    run_scen(3, 2, 0, 0, 60, 0, 0, 1'b1, "R3 top0");
    run_scen(3, 3, 1, 1, 60, 0, 0, 1'b1, "R3 top1");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule